// File: doc/BRIEF.md
# Framebuffer Word-to-Pixel Unpacker

This block takes a stream of 32-bit words fetched from a framebuffer and turns each word into a sequence of 24-bit RGB pixels. Both sides use a valid/ready handshake. A 3-bit depth code selects how pixels are packed in a word: 1, 2, 4 or 8 bits per pixel as colour indices, three 16-bit direct-colour packings, or 24-bit direct colour. Two separate bits set the order of bytes in the word and the order of sub-byte pixels in a byte. A third bit exchanges the red and blue outputs.

Indexed depths look up a 256-entry palette. Each entry is 16 bits wide and is written through a plain write port. The depth, ordering and swap inputs are sampled when a word is accepted, so they may change while earlier words are still being unpacked. An upstream fetch engine feeds the input side, and a timing generator drains pixels from the output side.

Top module: `fb_pix_unpack`

## Requirements
- R1: Depth code on `depthCode`: 0=1 bpp, 1=2 bpp, 2=4 bpp, 3=8 bpp, 4=16 bpp 1:5:5:5, 5=24 bpp, 6=16 bpp 5:6:5, 7=16 bpp 4:4:4. Each word yields 32/bpp pixels, except 24 bpp, which yields exactly one pixel.
- R2: With `byteBigEnd`=0, the first pixels come from the least significant byte or halfword of the word; with 1, they come from the most significant. In 24 bpp the pixel is always bits [23:0], and bits [31:24] and `byteBigEnd` have no effect.
- R3: For 1, 2 and 4 bpp, `pixBigEnd`=0 takes the first pixel of a byte from its lowest bits and 1 takes it from its highest bits. At 8 bpp and wider, `pixBigEnd` has no effect.
- R4: Indexed depths use the pixel value as a palette address. The entry is decoded as red [14:10], green [9:5] and blue [4:0], and bit 15 is ignored.
- R5: Direct 16-bit codes decode as follows: code 4 is red [14:10], green [9:5], blue [4:0], with bit 15 ignored; code 6 is red [15:11], green [10:5], blue [4:0]; code 7 is red [11:8], green [7:4], blue [3:0], with [15:12] ignored. In 24 bpp, red is [23:16], green [15:8] and blue [7:0]. An n-bit component is widened to 8 bits by appending its top 8-n bits below it.
- R6: `outPix` carries red in [23:16], green in [15:8] and blue in [7:0]. When `swapRB`=1, the [23:16] and [7:0] fields are exchanged.
- R7: While `outValid`=1 and `outReady`=0, the pixel is held unchanged (absent palette writes). Pixels are neither lost nor repeated.
- R8: `inReady` is 1 when no pixel is pending, or when the last pixel of the held word is taken in that cycle; otherwise it is 0. A word accepted together with that last pixel is presented in the next cycle with no idle cycle.
- R9: The format inputs are captured with each accepted word. Changing them afterwards does not alter that word's pixels.
- R10: A palette write takes effect from the next cycle. A pixel shown in the same cycle as the write uses the previous entry.
- R11: After reset, `outValid`=0 and `inReady`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| depthCode | input | 3 | Packing code, sampled on word accept |
| byteBigEnd | input | 1 | Byte order within the word |
| pixBigEnd | input | 1 | Pixel order within a byte |
| swapRB | input | 1 | Exchange red and blue outputs |
| inData | input | 32 | Framebuffer word |
| inValid | input | 1 | Word available |
| inReady | output | 1 | Word can be taken |
| outPix | output | 24 | RGB pixel |
| outValid | output | 1 | Pixel available |
| outReady | input | 1 | Pixel consumer ready |
| palWrEn | input | 1 | Palette write strobe |
| palWrAddr | input | 8 | Palette write address |
| palWrData | input | 16 | Palette write data |

## Verification
Two pairs of events can coincide and are each forced in the same cycle. The first pair is acceptance of the next word and emission of the last pixel of the current word. The bench offers a new word at the moment the consumer takes the final pixel. It expects `inReady` high in that cycle and the new word's first pixel in the following cycle. The second pair is a palette write and an indexed pixel that reads the same entry. The pixel is stalled and the entry is rewritten; the old colour must still show in the write cycle and the new colour one cycle later.

// File: rtl/pxu_pkg.sv
`timescale 1ns/1ps
package pxu_pkg;
  localparam int WORD_W = 32;
  localparam int PIX_W  = 24;
  localparam int IDX_W  = $clog2(WORD_W);

  typedef enum logic [2:0] {
    DEP_1       = 3'd0,
    DEP_2       = 3'd1,
    DEP_4       = 3'd2,
    DEP_8       = 3'd3,
    DEP_16_1555 = 3'd4,
    DEP_24      = 3'd5,
    DEP_16_565  = 3'd6,
    DEP_16_444  = 3'd7
  } depth_e;

  typedef struct packed {
    depth_e depth;
    logic   byteBE;
    logic   pixBE;
    logic   swapRB;
  } fmtCfg_t;

  // control -> datapath strobes
  typedef struct packed {
    logic             loadWord;
    logic [IDX_W-1:0] pixIdx;
  } ctrlStrobe_t;

  // log2 of bits per pixel; all 16-bit packings give 4, 24 bpp is handled apart
  function automatic logic [2:0] bppLog(depth_e d);
    case (d)
      DEP_1:   return 3'd0;
      DEP_2:   return 3'd1;
      DEP_4:   return 3'd2;
      DEP_8:   return 3'd3;
      default: return 3'd4;
    endcase
  endfunction

  function automatic logic [IDX_W-1:0] lastPixIdx(depth_e d);
    if (d == DEP_24) return '0;
    return IDX_W'((WORD_W - 1) >> bppLog(d));
  endfunction

  function automatic logic [7:0] widen4(logic [3:0] c);
    return {c, c};
  endfunction

  function automatic logic [7:0] widen5(logic [4:0] c);
    return {c, c[4:2]};
  endfunction

  function automatic logic [7:0] widen6(logic [5:0] c);
    return {c, c[5:4]};
  endfunction
endpackage

// File: rtl/pxu_control.sv
`timescale 1ns/1ps
module pxu_control
  import pxu_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic        outReady,
  input  depth_e      curDepth,
  output logic        inReady,
  output logic        outValid,
  output ctrlStrobe_t strobe
);
  logic             wordFull;
  logic [IDX_W-1:0] pixIdx;
  logic             lastPix;
  logic             fire;
  logic             accept;

  always_comb begin
    lastPix  = (pixIdx == lastPixIdx(curDepth));
    fire     = wordFull & outReady;
    inReady  = ~wordFull | (lastPix & outReady);
    accept   = inValid & inReady;
    outValid = wordFull;
    strobe.loadWord = accept;
    strobe.pixIdx   = pixIdx;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wordFull <= 1'b0;
      pixIdx   <= '0;
    end else if (accept) begin
      wordFull <= 1'b1;
      pixIdx   <= '0;
    end else if (fire && lastPix) begin
      wordFull <= 1'b0;
      pixIdx   <= '0;
    end else if (fire) begin
      pixIdx   <= pixIdx + 1'b1;
    end
  end
endmodule

// File: rtl/pxu_datapath.sv
`timescale 1ns/1ps
module pxu_datapath
  import pxu_pkg::*;
#(
  parameter int PAL_ENTRIES = 256,
  parameter int PAL_W       = 16,
  localparam int PAL_AW     = $clog2(PAL_ENTRIES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [WORD_W-1:0] inData,
  input  fmtCfg_t           cfgIn,
  input  logic              palWrEn,
  input  logic [PAL_AW-1:0] palWrAddr,
  input  logic [PAL_W-1:0]  palWrData,
  output depth_e            curDepth,
  output logic [PIX_W-1:0]  outPix
);
  logic [WORD_W-1:0] wordReg;
  fmtCfg_t           cfgReg;
  logic [PAL_W-1:0]  palMem [PAL_ENTRIES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wordReg <= '0;
      cfgReg  <= '0;
    end else if (strobe.loadWord) begin
      wordReg <= inData;
      cfgReg  <= cfgIn;
    end
  end

  always_ff @(posedge clk) begin
    if (palWrEn) palMem[palWrAddr] <= palWrData;
  end

  assign curDepth = cfgReg.depth;

  // bit offset of the selected pixel in the held word
  logic [2:0]        lg;
  logic [IDX_W-1:0]  idx;
  logic [IDX_W-1:0]  byteSel;
  logic [IDX_W-1:0]  slotMask;
  logic [IDX_W-1:0]  slotOffN;
  logic [5:0]        slotOff;
  logic [5:0]        baseOff;
  logic [5:0]        bitOff;
  logic [WORD_W-1:0] raw;

  always_comb begin
    lg       = bppLog(cfgReg.depth);
    idx      = strobe.pixIdx;
    byteSel  = idx >> (3'd3 - lg);
    slotMask = (IDX_W'(1) << (3'd3 - lg)) - IDX_W'(1);
    slotOffN = (idx & slotMask) << lg;
    slotOff  = {1'b0, slotOffN};
    baseOff  = cfgReg.byteBE ? {1'b0, 2'd3 - byteSel[1:0], 3'b000}
                             : {1'b0, byteSel[1:0], 3'b000};
    if (cfgReg.depth == DEP_24) begin
      bitOff = 6'd0;
    end else if (lg == 3'd4) begin
      bitOff = (cfgReg.byteBE ^ idx[0]) ? 6'd16 : 6'd0;
    end else if (cfgReg.pixBE) begin
      bitOff = baseOff + (6'd8 - (6'd1 << lg) - slotOff);
    end else begin
      bitOff = baseOff + slotOff;
    end
    raw = wordReg >> bitOff;
  end

  // palette lookup for indexed depths
  logic [PAL_AW-1:0] idxMask;
  logic [PAL_AW-1:0] palIdx;
  logic [PAL_W-1:0]  palEntry;

  always_comb begin
    idxMask  = {PAL_AW{1'b1}} >> (PAL_AW - (32'd1 << lg));
    palIdx   = raw[PAL_AW-1:0] & idxMask;
    palEntry = palMem[palIdx];
  end

  logic [7:0] red, green, blue;

  always_comb begin
    case (cfgReg.depth)
      DEP_1, DEP_2, DEP_4, DEP_8: begin
        red   = widen5(palEntry[14:10]);
        green = widen5(palEntry[9:5]);
        blue  = widen5(palEntry[4:0]);
      end
      DEP_16_1555: begin
        red   = widen5(raw[14:10]);
        green = widen5(raw[9:5]);
        blue  = widen5(raw[4:0]);
      end
      DEP_16_565: begin
        red   = widen5(raw[15:11]);
        green = widen6(raw[10:5]);
        blue  = widen5(raw[4:0]);
      end
      DEP_16_444: begin
        red   = widen4(raw[11:8]);
        green = widen4(raw[7:4]);
        blue  = widen4(raw[3:0]);
      end
      default: begin
        red   = raw[23:16];
        green = raw[15:8];
        blue  = raw[7:0];
      end
    endcase
    outPix = cfgReg.swapRB ? {blue, green, red} : {red, green, blue};
  end

  logic unusedBits;
  assign unusedBits = ^{raw[WORD_W-1:24], palEntry[PAL_W-1:15]};
endmodule

// File: rtl/fb_pix_unpack.sv
`timescale 1ns/1ps
module fb_pix_unpack
  import pxu_pkg::*;
#(
  parameter int PAL_ENTRIES = 256,
  parameter int PAL_W       = 16,
  localparam int PAL_AW     = $clog2(PAL_ENTRIES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        depthCode,
  input  logic              byteBigEnd,
  input  logic              pixBigEnd,
  input  logic              swapRB,
  input  logic [WORD_W-1:0] inData,
  input  logic              inValid,
  output logic              inReady,
  output logic [PIX_W-1:0]  outPix,
  output logic              outValid,
  input  logic              outReady,
  input  logic              palWrEn,
  input  logic [PAL_AW-1:0] palWrAddr,
  input  logic [PAL_W-1:0]  palWrData
);
  ctrlStrobe_t strobe;
  depth_e      curDepth;
  fmtCfg_t     cfgIn;

  assign cfgIn = '{depth: depth_e'(depthCode), byteBE: byteBigEnd,
                   pixBE: pixBigEnd, swapRB: swapRB};

  pxu_control u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .outReady (outReady),
    .curDepth (curDepth),
    .inReady  (inReady),
    .outValid (outValid),
    .strobe   (strobe)
  );

  pxu_datapath #(.PAL_ENTRIES(PAL_ENTRIES), .PAL_W(PAL_W)) u_data (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .inData    (inData),
    .cfgIn     (cfgIn),
    .palWrEn   (palWrEn),
    .palWrAddr (palWrAddr),
    .palWrData (palWrData),
    .curDepth  (curDepth),
    .outPix    (outPix)
  );
endmodule

// File: rtl/pxu_checker.sv
`timescale 1ns/1ps
module pxu_checker (
  input logic        clk,
  input logic        rstN,
  input logic [2:0]  depthCode,
  input logic        inValid,
  input logic        inReady,
  input logic [23:0] outPix,
  input logic        outValid,
  input logic        outReady,
  input logic        palWrEn
);
  logic       accept, fire;
  logic       seen;
  logic [2:0] heldCode;
  logic [5:0] fireCnt;
  logic [5:0] wantCnt;
  logic [5:0] gotCnt;

  assign accept = inValid & inReady;
  assign fire   = outValid & outReady;

  always_comb begin
    case (heldCode)
      3'd0:    wantCnt = 6'd32;
      3'd1:    wantCnt = 6'd16;
      3'd2:    wantCnt = 6'd8;
      3'd3:    wantCnt = 6'd4;
      3'd5:    wantCnt = 6'd1;
      default: wantCnt = 6'd2;
    endcase
    gotCnt = fireCnt + {5'd0, fire};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seen     <= 1'b0;
      heldCode <= '0;
      fireCnt  <= '0;
    end else if (accept) begin
      seen     <= 1'b1;
      heldCode <= depthCode;
      fireCnt  <= '0;
    end else if (fire) begin
      fireCnt  <= fireCnt + 6'd1;
    end
  end

  // R1: a word is replaced only after exactly 32/bpp (or 1) pixels left
  a_r1_pix_count: assert property (@(posedge clk) disable iff (!rstN)
    accept && seen |-> gotCnt == wantCnt);

  // R7: stalled pixel holds
  a_r7_hold_stalled: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady && !palWrEn |=> outValid && $stable(outPix));

  // R8: no acceptance while a pixel is stuck
  a_r8_no_early_accept: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |-> !inReady);

  // R8: empty unpacker takes words
  a_r8_idle_ready: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> inReady);

  // R8: accepted word is presented next cycle
  a_r8_accept_presents: assert property (@(posedge clk) disable iff (!rstN)
    accept |=> outValid);
endmodule

bind fb_pix_unpack pxu_checker u_pxu_checker (
  .clk       (clk),
  .rstN      (rstN),
  .depthCode (depthCode),
  .inValid   (inValid),
  .inReady   (inReady),
  .outPix    (outPix),
  .outValid  (outValid),
  .outReady  (outReady),
  .palWrEn   (palWrEn)
);

// File: tb/tb_fb_pix_unpack.sv
`timescale 1ns/1ps
module tb_fb_pix_unpack;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  depthCode = '0;
  logic        byteBigEnd = 1'b0, pixBigEnd = 1'b0, swapRB = 1'b0;
  logic [31:0] inData = '0;
  logic        inValid = 1'b0;
  logic        inReady;
  logic [23:0] outPix;
  logic        outValid;
  logic        outReady = 1'b0;
  logic        palWrEn = 1'b0;
  logic [7:0]  palWrAddr = '0;
  logic [15:0] palWrData = '0;

  logic [15:0] palShadow [256];
  int nChecks = 0;
  int nFail = 0;

  always #2.5 clk = ~clk;

  fb_pix_unpack dut (
    .clk(clk), .rstN(rstN), .depthCode(depthCode), .byteBigEnd(byteBigEnd),
    .pixBigEnd(pixBigEnd), .swapRB(swapRB), .inData(inData), .inValid(inValid),
    .inReady(inReady), .outPix(outPix), .outValid(outValid), .outReady(outReady),
    .palWrEn(palWrEn), .palWrAddr(palWrAddr), .palWrData(palWrData)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] up5(logic [4:0] c); return {c, c[4:2]}; endfunction
  function automatic logic [7:0] up6(logic [5:0] c); return {c, c[5:4]}; endfunction
  function automatic logic [7:0] up4(logic [3:0] c); return {c, c}; endfunction

  function automatic int pixPerWord(logic [2:0] code);
    if (code == 3'd5) return 1;
    if (code < 3'd4) return 32 >> code;
    return 2;
  endfunction

  // expected pixel k of word w, from the requirement text
  function automatic logic [23:0] refPix(logic [31:0] w, logic [2:0] code,
                                         logic be, logic pbe, logic sw, int k);
    int b;
    logic [31:0] v;
    logic [7:0] r, g, bl, byt;
    logic [15:0] e;
    b = (code < 3'd4) ? (1 << code) : ((code == 3'd5) ? 24 : 16);
    if (b == 24) v = {8'h0, w[23:0]};
    else if (b == 16) v = {16'h0, be ? w[31-16*k -: 16] : w[16*k +: 16]};
    else if (b == 8) v = {24'h0, be ? w[31-8*k -: 8] : w[8*k +: 8]};
    else begin
      int per, j, s, sh;
      per = 8 / b; j = k / per; s = k % per;
      byt = be ? w[31-8*j -: 8] : w[8*j +: 8];
      sh = pbe ? (8 - b - s*b) : s*b;
      v = {24'h0, (byt >> sh) & 8'((1 << b) - 1)};
    end
    case (code)
      3'd4:    begin r = up5(v[14:10]); g = up5(v[9:5]); bl = up5(v[4:0]); end
      3'd6:    begin r = up5(v[15:11]); g = up6(v[10:5]); bl = up5(v[4:0]); end
      3'd7:    begin r = up4(v[11:8]); g = up4(v[7:4]); bl = up4(v[3:0]); end
      3'd5:    begin r = v[23:16]; g = v[15:8]; bl = v[7:0]; end
      default: begin
        e = palShadow[v[7:0]];
        r = up5(e[14:10]); g = up5(e[9:5]); bl = up5(e[4:0]);
      end
    endcase
    return sw ? {bl, g, r} : {r, g, bl};
  endfunction

  task automatic setFmt(logic [2:0] code, logic be, logic pbe, logic sw);
    depthCode = code; byteBigEnd = be; pixBigEnd = pbe; swapRB = sw;
  endtask

  task automatic palWrite(logic [7:0] a, logic [15:0] d);
    @(negedge clk);
    palWrEn = 1'b1; palWrAddr = a; palWrData = d;
    @(posedge clk); #1;
    palWrEn = 1'b0;
    palShadow[a] = d;
  endtask

  task automatic pushWord(logic [31:0] w);
    @(negedge clk);
    inData = w; inValid = 1'b1; #1;
    while (!inReady) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    inValid = 1'b0;
  endtask

  task automatic popPix(string req, logic [23:0] exp);
    @(negedge clk);
    outReady = 1'b1; #1;
    chk(req, "outValid", {31'h0, outValid}, 32'h1);
    chk(req, "outPix", {8'h0, outPix}, {8'h0, exp});
    @(posedge clk); #1;
    outReady = 1'b0;
  endtask

  task automatic runWord(string req, logic [31:0] w, logic [2:0] code,
                         logic be, logic pbe, logic sw);
    int n;
    n = pixPerWord(code);
    setFmt(code, be, pbe, sw);
    pushWord(w);
    for (int k = 0; k < n; k++) popPix(req, refPix(w, code, be, pbe, sw, k));
    @(negedge clk); #1;
    chk(req, "drained", {31'h0, outValid}, 32'h0);
  endtask

  task automatic t_reset;
    @(negedge clk); #1;
    chk("R11", "outValid", {31'h0, outValid}, 32'h0);
    chk("R11", "inReady", {31'h0, inReady}, 32'h1);
  endtask

  task automatic t_loadPalette;
    for (int i = 0; i < 256; i++) palWrite(8'(i), 16'((i * 32'h3A7) ^ 32'hC5B1));
  endtask

  task automatic t_modes;
    runWord("R1_R4", 32'hA5C3_0F01, 3'd0, 1'b0, 1'b0, 1'b0);
    runWord("R2_R3", 32'h1B2D_E487, 3'd1, 1'b1, 1'b1, 1'b0);
    runWord("R3", 32'h9E3C_5A71, 3'd2, 1'b0, 1'b1, 1'b0);
    runWord("R2", 32'hF0E1_D2C3, 3'd3, 1'b1, 1'b1, 1'b0);
    runWord("R6", 32'h1234_ABCD, 3'd3, 1'b0, 1'b0, 1'b1);
    runWord("R5", 32'hC21F_83E0, 3'd4, 1'b0, 1'b0, 1'b0);
    runWord("R5_R2", 32'hF81F_07E0, 3'd6, 1'b1, 1'b0, 1'b0);
    runWord("R5_R6", 32'hA5C3_7E19, 3'd7, 1'b0, 1'b0, 1'b1);
    runWord("R5_R2", 32'hEE12_3456, 3'd5, 1'b1, 1'b0, 1'b0);
    runWord("R6", 32'h77A1_B2C3, 3'd5, 1'b0, 1'b0, 1'b1);
  endtask

  task automatic t_stall;
    logic [31:0] w;
    w = 32'h4433_2211;
    setFmt(3'd3, 1'b0, 1'b0, 1'b0);
    pushWord(w);
    for (int c = 0; c < 3; c++) begin
      @(negedge clk); #1;
      chk("R7", "held valid", {31'h0, outValid}, 32'h1);
      chk("R7", "held pix", {8'h0, outPix}, {8'h0, refPix(w, 3'd3, 1'b0, 1'b0, 1'b0, 0)});
      chk("R8", "stalled inReady", {31'h0, inReady}, 32'h0);
    end
    for (int k = 0; k < 4; k++) popPix("R7", refPix(w, 3'd3, 1'b0, 1'b0, 1'b0, k));
  endtask

  task automatic t_backToBack;
    logic [31:0] w1, w2;
    w1 = 32'h83E0_7C1F; w2 = 32'h1234_5678;
    setFmt(3'd6, 1'b0, 1'b0, 1'b0);
    pushWord(w1);
    popPix("R8", refPix(w1, 3'd6, 1'b0, 1'b0, 1'b0, 0));
    @(negedge clk);
    outReady = 1'b1; inValid = 1'b1; inData = w2; #1;
    chk("R8", "ready on last", {31'h0, inReady}, 32'h1);
    chk("R8", "last pix", {8'h0, outPix}, {8'h0, refPix(w1, 3'd6, 1'b0, 1'b0, 1'b0, 1)});
    @(posedge clk); #1;
    inValid = 1'b0; outReady = 1'b0;
    @(negedge clk); #1;
    chk("R8", "no bubble", {31'h0, outValid}, 32'h1);
    chk("R8", "next word pix", {8'h0, outPix}, {8'h0, refPix(w2, 3'd6, 1'b0, 1'b0, 1'b0, 0)});
    popPix("R8", refPix(w2, 3'd6, 1'b0, 1'b0, 1'b0, 0));
    popPix("R8", refPix(w2, 3'd6, 1'b0, 1'b0, 1'b0, 1));
  endtask

  task automatic t_cfgLatch;
    logic [31:0] w;
    w = 32'hC3A5_1E97;
    setFmt(3'd2, 1'b0, 1'b0, 1'b0);
    pushWord(w);
    setFmt(3'd5, 1'b1, 1'b1, 1'b1);
    for (int k = 0; k < 8; k++) popPix("R9", refPix(w, 3'd2, 1'b0, 1'b0, 1'b0, k));
  endtask

  task automatic t_palRace;
    logic [31:0] w;
    logic [23:0] oldPix;
    w = 32'h4433_2233;
    setFmt(3'd3, 1'b0, 1'b0, 1'b0);
    pushWord(w);
    oldPix = refPix(w, 3'd3, 1'b0, 1'b0, 1'b0, 0);
    @(negedge clk);
    palWrEn = 1'b1; palWrAddr = 8'h33; palWrData = 16'h7C00; #1;
    chk("R10", "old entry in write cycle", {8'h0, outPix}, {8'h0, oldPix});
    @(posedge clk); #1;
    palWrEn = 1'b0;
    palShadow[8'h33] = 16'h7C00;
    @(negedge clk); #1;
    chk("R10", "new entry next cycle", {8'h0, outPix}, 32'h00FF_0000);
    for (int k = 0; k < 4; k++) popPix("R10", refPix(w, 3'd3, 1'b0, 1'b0, 1'b0, k));
  endtask

  task automatic finishRun;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  endtask

  initial begin
    #(5.0 * 100000);
    nChecks++; nFail++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_loadPalette();
    t_modes();
    t_stall();
    t_backToBack();
    t_cfgLatch();
    t_palRace();
    repeat (2) @(negedge clk);
    finishRun();
  end
endmodule